// File: doc/BRIEF.md
# Single-Wire Network Address Command Layer

This block runs the addressing stage that a slave device on a single-wire, open-drain bus goes through after every bus reset. A bit-level transceiver passes it each bit the master writes and each read slot the master opens. The block collects an 8-bit address command, least significant bit first, then does one of four things. It shifts out its own 64-bit network address. It compares an address the master sends against its own. It selects itself at once. Or it takes part in the bitwise search arbitration the master uses to list every device on the bus.

The 64-bit address is built inside the block. The low byte is a family code set by a parameter, the next 48 bits are a serial number taken from an input port, and the top byte is a CRC-8 that an attached unit computes over the lower 56 bits. When addressing succeeds, the block raises `selected`, which lets the function-command layer that follows take over the bus. When addressing fails, or the command is not one it knows, the block stays silent until the next bus reset.

Top module: `ow_netaddr_ctl`

## Requirements
- R1: After the synchronous reset `rst`, `selected` and `rd_ack` are low. A read slot opened before any command is received gets no acknowledge.
- R2: Command 33h makes the block answer the next 64 read slots with its address bits, bit 0 first. Each answer is one `rd_ack` pulse, with `rd_bit` valid, in the cycle after `rd_req`. `selected` rises with the 64th answer. Once selected, the block acknowledges no further read slots.
- R3: Address bits [7:0] hold the family code (default 09h). Bits [55:8] hold `serial_no`. Bits [63:56] hold the CRC-8 of bits [55:0]: polynomial x^8+x^5+x^4+1, register initialised to zero, input bits fed from bit 0 upward, register shifted right with feedback constant 8Ch.
- R4: Command 55h is followed by 64 written bits, bit 0 first. `selected` rises only if all 64 bits equal the address. After any mismatch, the block acknowledges no read slot and cannot be selected until a bus reset.
- R5: Command CCh raises `selected` on the eighth command bit, with no address phase.
- R6: Command F0h runs search. For each address bit from 0 to 63, the block answers two read slots, first with the address bit and then with its complement, and then takes one written bit.
- R7: During search, a written bit that differs from the address bit drops the block out of the search. It then acknowledges no read slot and stays unselected until a bus reset.
- R8: When the 64th search bit is written and matches, `selected` rises.
- R9: Any other command value puts the block into a silent state. There, later command bytes (even CCh) and read slots get no response until a bus reset.
- R10: A `bus_reset` pulse in any state clears `selected`, drops any partial command, match or search progress, and returns the block to collecting a command.
- R11: A read slot outside a sending step gets no acknowledge. This covers command collection, the match phase and the third step of a search position. Bits written during an address read do not move the read position.
- R12: Command bits are taken least significant first, so bytes 33h and CCh, which are bit reversals of each other, are decoded as different commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| serial_no | input | 48 | Serial-number part of the network address |
| bus_reset | input | 1 | One-cycle pulse: the transceiver saw a reset/presence sequence |
| wr_valid | input | 1 | One-cycle pulse: the master wrote a bit |
| wr_bit | input | 1 | Value of the written bit |
| rd_req | input | 1 | One-cycle pulse: the master opened a read slot |
| rd_ack | output | 1 | One-cycle pulse: the block supplies the bit for the read slot |
| rd_bit | output | 1 | Bit to present, valid with `rd_ack`; 1 when released |
| selected | output | 1 | Addressing succeeded; the function layer may proceed |

## Verification
The hardest cases to reach are the late drop-outs. Search and match must run deep into the address before a single wrong bit arrives, and the bench then has to show that later read slots, and even a later skip command, get no answer. The bench reaches them by driving a correct prefix computed from its own model of the address (family code, serial number and its own CRC-8). It then flips one chosen bit, keeps sending traffic, and watches `rd_ack` and `selected`. A bus reset issued part-way through a search is followed by a fresh search, which must restart at address bit 0.

// File: rtl/ow_addr_pkg.sv
package ow_addr_pkg;

  typedef enum logic [2:0] {
    ST_CMD    = 3'd0,
    ST_READ   = 3'd1,
    ST_MATCH  = 3'd2,
    ST_SEARCH = 3'd3,
    ST_SEL    = 3'd4,
    ST_IDLE   = 3'd5
  } addr_state_t;

  typedef enum logic [1:0] {
    SP_BIT  = 2'd0,
    SP_INV  = 2'd1,
    SP_PICK = 2'd2
  } search_phase_t;

  localparam logic [7:0] OP_READ   = 8'h33;
  localparam logic [7:0] OP_MATCH  = 8'h55;
  localparam logic [7:0] OP_SKIP   = 8'hCC;
  localparam logic [7:0] OP_SEARCH = 8'hF0;

endpackage

// File: rtl/ow_addr_crc8.sv
module ow_addr_crc8 #(
  parameter int          DATA_W = 56,
  parameter logic [7:0]  POLY_R = 8'h8C
) (
  input  logic [DATA_W-1:0] data,
  output logic [7:0]        crc
);

  // Reflected CRC-8, zero start, bit 0 of data enters first.
  always_comb begin
    logic [7:0] c;
    logic       fb;
    c = 8'h00;
    for (int i = 0; i < DATA_W; i++) begin
      fb = c[0] ^ data[i];
      c  = c >> 1;
      if (fb) c = c ^ POLY_R;
    end
    crc = c;
  end

endmodule

// File: rtl/ow_cmd_shift.sv
module ow_cmd_shift #(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             din,
  output logic             done,
  output logic [CMD_W-1:0] cmd
);

  localparam int CNT_W = $clog2(CMD_W);

  logic [CMD_W-1:0] sh_q;
  logic [CNT_W-1:0] cnt_q;

  // Bits arrive least significant first and shift in from the top.
  assign done = en && (cnt_q == CNT_W'(CMD_W-1));
  assign cmd  = {din, sh_q[CMD_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (en) begin
      sh_q  <= {din, sh_q[CMD_W-1:1]};
      cnt_q <= done ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/ow_netaddr_ctl.sv
module ow_netaddr_ctl
  import ow_addr_pkg::*;
#(
  parameter logic [7:0] FAMILY = 8'h09,
  parameter int         SER_W  = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SER_W-1:0] serial_no,
  input  logic             bus_reset,
  input  logic             wr_valid,
  input  logic             wr_bit,
  input  logic             rd_req,
  output logic             rd_ack,
  output logic             rd_bit,
  output logic             selected
);

  localparam int BODY_W = SER_W + 8;
  localparam int ADDR_W = BODY_W + 8;
  localparam int IDX_W  = $clog2(ADDR_W);

  addr_state_t     state_q;
  search_phase_t   phase_q;
  logic [IDX_W-1:0] idx_q;

  logic [7:0]        crc;
  logic [ADDR_W-1:0] net_addr;
  logic              cur_bit;
  logic              idx_last;
  logic              cmd_en;
  logic              cmd_done;
  logic [7:0]        cmd_byte;

  ow_addr_crc8 #(.DATA_W(BODY_W), .POLY_R(8'h8C)) u_crc (
    .data ({serial_no, FAMILY}),
    .crc  (crc)
  );

  assign net_addr = {crc, serial_no, FAMILY};
  assign cur_bit  = net_addr[idx_q];
  assign idx_last = (idx_q == IDX_W'(ADDR_W-1));
  assign cmd_en   = (state_q == ST_CMD) && wr_valid;

  ow_cmd_shift #(.CMD_W(8)) u_cmd (
    .clk  (clk),
    .rst  (rst),
    .clr  (bus_reset),
    .en   (cmd_en),
    .din  (wr_bit),
    .done (cmd_done),
    .cmd  (cmd_byte)
  );

  always_ff @(posedge clk) begin
    if (rst || bus_reset) begin
      state_q  <= ST_CMD;
      phase_q  <= SP_BIT;
      idx_q    <= '0;
      rd_ack   <= 1'b0;
      rd_bit   <= 1'b1;
      selected <= 1'b0;
    end else begin
      rd_ack <= 1'b0;
      rd_bit <= 1'b1;
      case (state_q)
        ST_CMD: begin
          if (cmd_done) begin
            idx_q   <= '0;
            phase_q <= SP_BIT;
            case (cmd_byte)
              OP_READ:   state_q <= ST_READ;
              OP_MATCH:  state_q <= ST_MATCH;
              OP_SEARCH: state_q <= ST_SEARCH;
              OP_SKIP: begin
                state_q  <= ST_SEL;
                selected <= 1'b1;
              end
              default:   state_q <= ST_IDLE;
            endcase
          end
        end
        ST_READ: begin
          if (rd_req) begin
            rd_ack <= 1'b1;
            rd_bit <= cur_bit;
            if (idx_last) begin
              state_q  <= ST_SEL;
              selected <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_MATCH: begin
          if (wr_valid) begin
            if (wr_bit != cur_bit) begin
              state_q <= ST_IDLE;
            end else if (idx_last) begin
              state_q  <= ST_SEL;
              selected <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_SEARCH: begin
          case (phase_q)
            SP_BIT: if (rd_req) begin
              rd_ack  <= 1'b1;
              rd_bit  <= cur_bit;
              phase_q <= SP_INV;
            end
            SP_INV: if (rd_req) begin
              rd_ack  <= 1'b1;
              rd_bit  <= ~cur_bit;
              phase_q <= SP_PICK;
            end
            SP_PICK: if (wr_valid) begin
              phase_q <= SP_BIT;
              if (wr_bit != cur_bit) begin
                state_q <= ST_IDLE;
              end else if (idx_last) begin
                state_q  <= ST_SEL;
                selected <= 1'b1;
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end
            default: phase_q <= SP_BIT;
          endcase
        end
        ST_SEL, ST_IDLE: ;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: an acknowledge only ever answers a read slot of the previous cycle
  a_r2_ack_answers_req: assert property (@(posedge clk) disable iff (rst)
    rd_ack |-> $past(rd_req));

  // R2: once selected for more than a cycle, the address layer stays off the line
  a_r2_quiet_when_selected: assert property (@(posedge clk) disable iff (rst)
    ($past(selected) && selected) |-> !rd_ack);

  // R9: the silent state never answers a read slot
  a_r9_idle_silent: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |=> !rd_ack);

  // R10: a bus reset always drops selection and any pending answer
  a_r10_bus_reset_clears: assert property (@(posedge clk) disable iff (rst)
    bus_reset |=> (!selected && !rd_ack));

  // R6: during search the two answers of one position are complementary
  a_r6_complement_pair: assert property (@(posedge clk) disable iff (rst || bus_reset)
    (rd_ack && state_q == ST_SEARCH && phase_q == SP_PICK && $past(phase_q) == SP_INV)
      |-> (rd_bit == ~net_addr[idx_q]));

endmodule

// File: tb/ow_netaddr_ctl_tb.sv
module ow_netaddr_ctl_tb;

  localparam logic [47:0] SER    = 48'h5A3C_9E17_B246;
  localparam logic [7:0]  FAM    = 8'h09;
  localparam int          WD_MAX = 150000;

  // Table: {opcode, selected after command, next read slot acknowledged}
  localparam int NVEC = 7;
  localparam logic [9:0] VEC [NVEC] = '{
    {8'h33, 1'b0, 1'b1},
    {8'h55, 1'b0, 1'b0},
    {8'hCC, 1'b1, 1'b0},
    {8'hF0, 1'b0, 1'b1},
    {8'h00, 1'b0, 1'b0},
    {8'hA5, 1'b0, 1'b0},
    {8'hFF, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_reset = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_bit = 1'b0;
  logic rd_req = 1'b0;
  logic rd_ack;
  logic rd_bit;
  logic selected;

  int applied = 0;
  int fails   = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  logic [63:0] exp_addr;
  logic [7:0]  exp_crc;

  always #4 clk = ~clk;

  ow_netaddr_ctl u_dut (
    .clk       (clk),
    .rst       (rst),
    .serial_no (SER),
    .bus_reset (bus_reset),
    .wr_valid  (wr_valid),
    .wr_bit    (wr_bit),
    .rd_req    (rd_req),
    .rd_ack    (rd_ack),
    .rd_bit    (rd_bit),
    .selected  (selected)
  );

  function automatic logic [7:0] ref_crc(input logic [55:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      logic fb = c[0] ^ d[i];
      c = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    applied++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse_bus_reset();
    @(negedge clk) bus_reset = 1'b1;
    @(negedge clk) bus_reset = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk) begin wr_valid = 1'b1; wr_bit = b; end
    @(negedge clk) wr_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic read_slot(output logic ack, output logic b);
    @(negedge clk) rd_req = 1'b1;
    @(negedge clk) begin rd_req = 1'b0; ack = rd_ack; b = rd_bit; end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WD_MAX && !done) begin
      fails++;
      applied++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_MAX);
      $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
    end
  end

  initial begin
    logic a, b, a2, b2;
    logic [63:0] got;
    int acks, errs;

    exp_crc  = ref_crc({SER, FAM});
    exp_addr = {exp_crc, SER, FAM};

    repeat (4) @(negedge clk);
    check("R1 selected after reset", 64'(selected), 64'd0);
    check("R1 rd_ack after reset", 64'(rd_ack), 64'd0);
    @(negedge clk) rst = 1'b0;
    read_slot(a, b);
    check("R11 R1 read slot before command", 64'(a), 64'd0);

    // Table walk: R2 R4 R5 R6 R9 R12
    for (int v = 0; v < NVEC; v++) begin
      pulse_bus_reset();
      send_byte(VEC[v][9:2]);
      check($sformatf("R5 R9 R12 selected op=%h", VEC[v][9:2]), 64'(selected), 64'(VEC[v][1]));
      read_slot(a, b);
      check($sformatf("R2 R6 R11 ack op=%h", VEC[v][9:2]), 64'(a), 64'(VEC[v][0]));
    end

    // Full address read: R2 R3
    pulse_bus_reset();
    send_byte(8'h33);
    acks = 0;
    got  = '0;
    for (int i = 0; i < 64; i++) begin
      read_slot(a, b);
      acks += a;
      got[i] = b;
    end
    check("R2 address read", got, exp_addr);
    check("R2 ack count", 64'(acks), 64'd64);
    check("R3 family byte", 64'(got[7:0]), 64'h09);
    check("R3 crc byte", 64'(got[63:56]), 64'(exp_crc));
    check("R2 selected after read", 64'(selected), 64'd1);
    read_slot(a, b);
    check("R2 no ack once selected", 64'(a), 64'd0);

    // Write bits during read ignored: R11
    pulse_bus_reset();
    send_byte(8'h33);
    got = '0;
    for (int i = 0; i < 3; i++) begin read_slot(a, b); got[i] = b; end
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    for (int i = 3; i < 64; i++) begin read_slot(a, b); got[i] = b; end
    check("R11 writes during read ignored", got, exp_addr);

    // Match correct: R4
    pulse_bus_reset();
    send_byte(8'h55);
    for (int i = 0; i < 64; i++) send_bit(exp_addr[i]);
    check("R4 match selects", 64'(selected), 64'd1);

    // Match wrong at bit 40: R4 R9 R10
    pulse_bus_reset();
    send_byte(8'h55);
    for (int i = 0; i < 64; i++) send_bit(i == 40 ? ~exp_addr[i] : exp_addr[i]);
    check("R4 mismatch not selected", 64'(selected), 64'd0);
    read_slot(a, b);
    check("R4 mismatch silent", 64'(a), 64'd0);
    send_byte(8'hCC);
    check("R4 skip ignored after mismatch", 64'(selected), 64'd0);
    pulse_bus_reset();
    send_byte(8'hCC);
    check("R10 skip after bus reset", 64'(selected), 64'd1);

    // Full search: R6 R8
    pulse_bus_reset();
    send_byte(8'hF0);
    errs = 0;
    for (int i = 0; i < 64; i++) begin
      read_slot(a, b);
      read_slot(a2, b2);
      if (!a || !a2 || b !== exp_addr[i] || b2 !== ~exp_addr[i]) errs++;
      send_bit(exp_addr[i]);
    end
    check("R6 search bit/complement pairs", 64'(errs), 64'd0);
    check("R8 search completes selected", 64'(selected), 64'd1);

    // Search drop at bit 10: R7
    pulse_bus_reset();
    send_byte(8'hF0);
    for (int i = 0; i < 11; i++) begin
      read_slot(a, b);
      read_slot(a2, b2);
      send_bit(i == 10 ? ~exp_addr[i] : exp_addr[i]);
    end
    read_slot(a, b);
    check("R7 dropped search silent", 64'(a), 64'd0);
    check("R7 dropped search unselected", 64'(selected), 64'd0);

    // Unknown then skip: R9
    pulse_bus_reset();
    send_byte(8'h12);
    send_byte(8'hCC);
    check("R9 skip after unknown", 64'(selected), 64'd0);
    read_slot(a, b);
    check("R9 unknown silent", 64'(a), 64'd0);

    // Bus reset mid-search restarts at bit 0: R10
    pulse_bus_reset();
    send_byte(8'hF0);
    for (int i = 0; i < 5; i++) begin
      read_slot(a, b);
      read_slot(a2, b2);
      send_bit(exp_addr[i]);
    end
    read_slot(a, b);
    pulse_bus_reset();
    check("R10 unselected after reset", 64'(selected), 64'd0);
    send_byte(8'hF0);
    read_slot(a, b);
    read_slot(a2, b2);
    check("R10 search restarts bit0", 64'({a, b, a2, b2}), 64'({1'b1, exp_addr[0], 1'b1, ~exp_addr[0]}));

    // Bus reset while selected: R10
    pulse_bus_reset();
    send_byte(8'hCC);
    pulse_bus_reset();
    check("R10 reset clears selected", 64'(selected), 64'd0);

    // Synchronous reset while selected: R1
    send_byte(8'hCC);
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check("R1 rst clears selected", 64'(selected), 64'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

endmodule